// File: doc/BRIEF.md
# GPIO Bank Interrupt Sense Unit

This block watches one bank of general-purpose input pins and raises an interrupt when a pin shows the event its configuration asks for. Each pin can be set to catch a falling edge, a rising edge, both edges, or a held high or low level. Events are latched per pin into a status word that software clears bit by bit. A single interrupt line is raised whenever an enabled pin has a pending status bit.

Software reaches five 32-bit words through a small register port with write strobe, read strobe, byte-offset address and data. There is one word for the enable mask, three sense-configuration planes and one status word. The pins come from the pad ring with no timing relation to the clock, so each one first passes through a two-flop synchroniser. Edge detection then compares the synchronised value with the value one clock earlier.

Top module: `gpio_irq_sense`

## Requirements
- R1: After reset, all five registers read zero and `irq` is low.
- R2: Register offsets are enable 0x00, plane A 0x04, plane B 0x08, plane C 0x0C and status 0x10. A written value reads back from the same offset while `rd_en` is high, and `rdata` is zero while `rd_en` is low.
- R3: A pin whose plane A, B and C bits are all 0 latches status on a falling edge only. A rising edge leaves status unchanged.
- R4: A pin with plane A = 1 and planes B and C = 0 latches status on a rising edge only.
- R5: A pin with plane C = 1 and plane B = 0 latches status on both a rising and a falling edge.
- R6: A pin with plane B = 1 is level sensitive: active high when plane A = 1, active low when plane A = 0. Its status bit is set again on every clock while the level stays active, so a clear does not persist while the level holds.
- R7: Plane B takes priority over plane C. A pin with B = 1, C = 1 and A = 1 held steadily high keeps latching status, as it would in level mode.
- R8: A pin whose enable bit is 0 never sets its status bit, whatever the pin does.
- R9: Writing 1 to a status bit clears it. Writing 0 leaves it as it was.
- R10: `irq` is high exactly when some status bit is 1 and its enable bit is also 1. Clearing the enable bit drops `irq` but leaves the status bit latched.
- R11: A pin change applied between clock edges shows up in status, and on `irq`, after the third rising clock edge that follows it, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational, zero when not reading |
| pins_in | input | 32 | Asynchronous pin inputs |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `wr_en` and `addr` are stable and free of X values whenever they are sampled at a clock edge. They also assume that any pin change reaches the block through the synchroniser and never directly into the status logic. The stimulus changes pins and register strobes only on falling clock edges. It never drives a write and a pin event that would touch the same status bit in the same cycle, so each latched bit can be traced to a single cause.

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense #(
  parameter int NPINS = 32,
  parameter int AW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] rdata,
  input  logic [NPINS-1:0] pins_in,
  output logic             irq
);
  localparam logic [AW-1:0] OFF_EN = AW'(5'h00);
  localparam logic [AW-1:0] OFF_PA = AW'(5'h04);
  localparam logic [AW-1:0] OFF_PB = AW'(5'h08);
  localparam logic [AW-1:0] OFF_PC = AW'(5'h0C);
  localparam logic [AW-1:0] OFF_ST = AW'(5'h10);

  logic [NPINS-1:0] en_q, pa_q, pb_q, pc_q, st_q;
  logic [NPINS-1:0] sy1_q, sy2_q, prv_q;
  logic [NPINS-1:0] rise, fall, edge_hit, lvl_hit, hit, clr;

  assign rise     = sy2_q & ~prv_q;
  assign fall     = ~sy2_q & prv_q;
  assign edge_hit = (pc_q & (rise | fall)) | (~pc_q & ((pa_q & rise) | (~pa_q & fall)));
  assign lvl_hit  = ~(sy2_q ^ pa_q);
  assign hit      = en_q & ((pb_q & lvl_hit) | (~pb_q & edge_hit));
  assign clr      = (wr_en && addr == OFF_ST) ? wdata : '0;
  assign irq      = |(st_q & en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      pa_q  <= '0;
      pb_q  <= '0;
      pc_q  <= '0;
      st_q  <= '0;
      sy1_q <= '0;
      sy2_q <= '0;
      prv_q <= '0;
    end else begin
      sy1_q <= pins_in;
      sy2_q <= sy1_q;
      prv_q <= sy2_q;
      if (wr_en && addr == OFF_EN) en_q <= wdata;
      if (wr_en && addr == OFF_PA) pa_q <= wdata;
      if (wr_en && addr == OFF_PB) pb_q <= wdata;
      if (wr_en && addr == OFF_PC) pc_q <= wdata;
      st_q <= (st_q & ~clr) | hit;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        OFF_EN:  rdata = en_q;
        OFF_PA:  rdata = pa_q;
        OFF_PB:  rdata = pb_q;
        OFF_PC:  rdata = pc_q;
        OFF_ST:  rdata = st_q;
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_sense_chk.sv
module gpio_irq_sense_chk #(
  parameter int NPINS = 32,
  parameter int AW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [AW-1:0]    addr,
  input logic [NPINS-1:0] wdata,
  input logic [NPINS-1:0] en,
  input logic [NPINS-1:0] pa,
  input logic [NPINS-1:0] pb,
  input logic [NPINS-1:0] sy2,
  input logic [NPINS-1:0] st,
  input logic             irq
);
  localparam logic [AW-1:0] OFF_ST = AW'(5'h10);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (st == '0 && !irq));

  // R8
  no_set_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st & ~$past(st) & ~$past(en)) == '0));

  // R9
  zero_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_ST && wdata == '0) |=> (($past(st) & ~st) == '0));

  // R9
  full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_ST && wdata == '1 && en == '0) |=> (st == '0 && !irq));

  // R6
  level_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st & $past(en & pb & pa & sy2)) == $past(en & pb & pa & sy2)));

  // R10
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq);
endmodule

bind gpio_irq_sense gpio_irq_sense_chk #(.NPINS(NPINS), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .en(en_q), .pa(pa_q), .pb(pb_q), .sy2(sy2_q), .st(st_q), .irq(irq)
);

// File: tb/gpio_irq_sense_tb_top.sv
module gpio_irq_sense_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pins = '0;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_sense dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pins_in(pins), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic cfg(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c, input logic [31:0] e);
    wr(5'h04, a); wr(5'h08, b); wr(5'h0C, c); wr(5'h00, e);
  endtask

  task automatic cleanup();
    wr(5'h00, '0); wr(5'h10, '1);
  endtask

  task automatic t_reset_regs();
    logic [31:0] d;
    rd(5'h00, d); chk("R1 enable", d, 0);
    rd(5'h04, d); chk("R1 plane A", d, 0);
    rd(5'h08, d); chk("R1 plane B", d, 0);
    rd(5'h0C, d); chk("R1 plane C", d, 0);
    rd(5'h10, d); chk("R1 status", d, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    wr(5'h04, 32'hA5A5_0000); wr(5'h08, 32'h0000_5A5A); wr(5'h0C, 32'h00FF_0000);
    rd(5'h04, d); chk("R2 plane A readback", d, 32'hA5A5_0000);
    rd(5'h08, d); chk("R2 plane B readback", d, 32'h0000_5A5A);
    rd(5'h0C, d); chk("R2 plane C readback", d, 32'h00FF_0000);
    @(negedge clk); addr = 5'h04; #1 chk("R2 rdata idle", rdata, 0);
    cfg(0, 0, 0, 0);
  endtask

  task automatic t_falling();
    logic [31:0] d;
    pins[0] = 1'b1; settle();
    cfg(0, 0, 0, 32'h1);
    pins[0] = 1'b0; settle();
    rd(5'h10, d); chk("R3 falling latched", d, 32'h1);
    chk("R10 irq on pending", {31'b0, irq}, 1);
    wr(5'h10, 32'h1);
    rd(5'h10, d); chk("R9 one clears", d, 0);
    chk("R10 irq after clear", {31'b0, irq}, 0);
    pins[0] = 1'b1; settle();
    rd(5'h10, d); chk("R3 rising ignored", d, 0);
    cleanup();
  endtask

  task automatic t_latency();
    cfg(32'h2, 0, 0, 32'h2);
    @(negedge clk); pins[1] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 not before third edge", {31'b0, irq}, 0);
    @(negedge clk);
    chk("R11 on third edge", {31'b0, irq}, 1);
    pins[1] = 1'b0; settle();
    chk("R4 falling ignored keeps state", {31'b0, irq}, 1);
    wr(5'h10, 32'h2); settle();
    chk("R4 no new event", {31'b0, irq}, 0);
    cleanup();
  endtask

  task automatic t_both();
    logic [31:0] d;
    cfg(0, 0, 32'h4, 32'h4);
    pins[2] = 1'b1; settle();
    rd(5'h10, d); chk("R5 rise latched", d, 32'h4);
    wr(5'h10, 32'h4);
    pins[2] = 1'b0; settle();
    rd(5'h10, d); chk("R5 fall latched", d, 32'h4);
    cleanup();
  endtask

  task automatic t_level();
    logic [31:0] d;
    cfg(32'h8, 32'h18, 0, 32'h8);
    pins[4] = 1'b1;
    pins[3] = 1'b1; settle();
    rd(5'h10, d); chk("R6 high level latched", d, 32'h8);
    wr(5'h10, 32'h8);
    rd(5'h10, d); chk("R6 clear does not persist", d, 32'h8);
    pins[3] = 1'b0; settle();
    wr(5'h10, 32'h8);
    rd(5'h10, d); chk("R6 clear after release", d, 0);
    wr(5'h00, 32'h10);
    pins[4] = 1'b0; settle();
    rd(5'h10, d); chk("R6 low level latched", d, 32'h10);
    pins[4] = 1'b1; settle();
    cleanup();
  endtask

  task automatic t_priority();
    logic [31:0] d;
    pins[5] = 1'b1; settle();
    cfg(32'h20, 32'h20, 32'h20, 32'h20);
    settle();
    wr(5'h10, 32'h20); settle();
    rd(5'h10, d); chk("R7 level wins over both-edge", d, 32'h20);
    pins[5] = 1'b0; settle();
    cleanup();
  endtask

  task automatic t_gate();
    logic [31:0] d;
    cfg(0, 0, 0, 0);
    pins[6] = 1'b1; settle();
    pins[6] = 1'b0; settle();
    rd(5'h10, d); chk("R8 disabled pin no status", d, 0);
    chk("R8 disabled pin no irq", {31'b0, irq}, 0);
    wr(5'h00, 32'h1);
    pins[0] = 1'b0; settle();
    rd(5'h10, d); chk("R3 second falling", d, 32'h1);
    wr(5'h10, 32'h0);
    rd(5'h10, d); chk("R9 zero write keeps", d, 32'h1);
    wr(5'h00, 32'h0);
    chk("R10 irq drops on disable", {31'b0, irq}, 0);
    rd(5'h10, d); chk("R10 status kept on disable", d, 32'h1);
    cleanup();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    fork
      begin
        t_reset_regs();
        t_falling();
        t_latency();
        t_both();
        t_level();
        t_priority();
        t_gate();
      end
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule